// File: doc/BRIEF.md
# Counter-Based Thermal Monitor Channel

This block is one channel of an on-die temperature monitor. A temperature-dependent ring oscillator runs faster than the reference clock. A front end that is not part of this block reports, on `osc_edges`, how many oscillator edges fell in each reference cycle. The channel adds these edges up over a programmable window. It repeats the measurement at a programmable interval and publishes the latest count together with a valid flag. A higher count means a hotter die.

Each finished count is compared against three 16-bit thresholds, which gives a thermal level from 0 (cold) to 3 (emergency). Each level has its own hardware action output: a throttle request, a clock-halving request and an emergency trip request. Each upward level change, and each counter overflow, can raise a sticky interrupt. Software configures the channel and clears the interrupt through a small synchronous register port. Read data comes back one cycle after the address is presented.

Top module: `thermal_count_monitor`

## Requirements
- R1: After reset, all registers read zero, all four outputs are low, and no count is published while the interval or window field is zero, whatever `osc_edges` carries.
- R2: Control word (offset 0x00): interval M in bits 23:8, window code N in bits 31:24.
  - The window covers the first 16·N reference cycles of each measurement period.
  - The published count is the sum of `osc_edges` over those cycles. It is read in bits 31:16 at offset 0x1C.
  - The valid flag is bit 9 at offset 0x18. It is set at the end of the first complete window.
- R3: A measurement period lasts max(M, 16·N) reference cycles and then repeats. The count and the level change only at the end of a window.
- R4: Thresholds:
  - A sits in bits 15:0 and B in bits 31:16 at offset 0x08; C sits in bits 15:0 at offset 0x0C.
  - The level is the highest of 1, 2 or 3 whose threshold (A, B or C) the count equals or exceeds, and 0 otherwise.
  - The level reads in bits 2:0 at offset 0x18.
- R5: A sum that reaches 0xFFFF saturates there and counts as overflow. The state field then reads 5, and the channel acts as level 3.
- R6: Control bit 0 stops measurement and clears the valid flag. Any write to the control word also clears the valid flag and restarts the window from its first cycle.
- R7: Action outputs, all low while the valid flag is clear:
  - `throttle_req` = control bit 3 and level ≥ 1.
  - `halve_req` = control bit 1 and level ≥ 2.
  - `trip_req` = control bit 2 and level 3.
- R8: The interrupt flag (bit 8 at offset 0x18, also on `irq`) is set at a window end in these cases:
  - the level rises to 1, 2 or 3 while control bit 3, 5 or 6 (respectively) is set;
  - the channel enters overflow while control bit 4 is set.
  A level that falls never sets it.
- R9: The interrupt flag is sticky. Writing the status word with bit 8 at one clears it, and writing it with bit 8 at zero leaves it unchanged.
- R10: Registers read back as written, except that control bit 7 and bits 31:16 at offset 0x0C always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_edges | input | EDGE_W | Oscillator edges seen in this reference cycle |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for last cycle's address |
| throttle_req | output | 1 | Level ≥ 1 throttle request |
| halve_req | output | 1 | Level ≥ 2 clock-halving request |
| trip_req | output | 1 | Level 3 emergency trip request |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The hardest condition to reach from the ports is overflow. It needs at least 65535 edges within one window, so the stimulus uses the longest practical window (N = 200, 3200 cycles) with `osc_edges` held at its maximum of 31. A second difficulty is that the level persists across restarts, which means a later window may show a fall rather than a rise. The level tests are therefore ordered so that rises and falls alternate on purpose. The repeat period cannot be read directly, so the bench holds the read address on the count register and measures, in cycles, the gap between two consecutive count changes. It does this once with M longer than the window and once with the window longer than M.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int CNT_W = 16;
    localparam int IVL_W = 16;
    localparam int WIN_W = 8;
    localparam int NUM_TH = 3;
    localparam int LVL_W = 2;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_THAB = 8'h08;
    localparam logic [7:0] OFF_THC  = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h18;
    localparam logic [7:0] OFF_CNT  = 8'h1C;

    localparam logic [2:0] STATE_OVF = 3'd5;

    // Control word; the field positions are fixed by software.
    typedef struct packed {
        logic [WIN_W-1:0] win_len;
        logic [IVL_W-1:0] ivl_len;
        logic             rsvd;
        logic             irq_l3_en;
        logic             irq_l2_en;
        logic             irq_ovf_en;
        logic             thr_en;
        logic             trip_en;
        logic             halve_en;
        logic             stop;
    } ctrl_t;

endpackage

// File: rtl/tmon_window.sv
module tmon_window #(
    parameter int CNT_W     = 16,
    parameter int EDGE_W    = 5,
    parameter int IVL_W     = 16,
    parameter int WIN_W     = 8,
    parameter int WIN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [IVL_W-1:0]  ivl_len,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [EDGE_W-1:0] edges,
    output logic              done,
    output logic [CNT_W-1:0]  result
);

    localparam int WL_W  = WIN_W + WIN_SHIFT;
    localparam int PER_W = (IVL_W > WL_W) ? IVL_W : WL_W;

    typedef struct packed {
        logic [PER_W-1:0] pos;
        logic [CNT_W-1:0] acc;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic [PER_W-1:0] wl, ivl, last;
    logic [CNT_W:0]   sum;

    always_comb begin
        wl     = PER_W'({win_len, {WIN_SHIFT{1'b0}}});
        ivl    = PER_W'(ivl_len);
        last   = ((ivl > wl) ? ivl : wl) - PER_W'(1);
        sum    = {1'b0, st_q.acc} + (CNT_W+1)'(edges);
        result = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        done   = 1'b0;
        st_d   = st_q;
        if (restart || !run) begin
            st_d = '0;
        end else begin
            if (st_q.pos < wl) begin
                if (st_q.pos == wl - PER_W'(1)) begin
                    done     = 1'b1;
                    st_d.acc = '0;
                end else begin
                    st_d.acc = result;
                end
            end
            st_d.pos = (st_q.pos == last) ? '0 : st_q.pos + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmon_level.sv
module tmon_level #(
    parameter int CNT_W  = 16,
    parameter int NUM_TH = 3,
    parameter int LVL_W  = 2
) (
    input  logic [NUM_TH-1:0][CNT_W-1:0] thr,
    input  logic [CNT_W-1:0]             count,
    output logic [LVL_W-1:0]             level,
    output logic                         ovf
);

    logic [NUM_TH-1:0] meet;

    for (genvar g = 0; g < NUM_TH; g++) begin : g_cmp
        assign meet[g] = (count >= thr[g]);
    end

    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_TH; i++) begin
            if (meet[i]) level = LVL_W'(i + 1);
        end
        ovf = &count;
    end

endmodule

// File: rtl/thermal_count_monitor.sv
module thermal_count_monitor
    import tmon_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int EDGE_W    = 5,
    parameter int WIN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EDGE_W-1:0] osc_edges,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              throttle_req,
    output logic              halve_req,
    output logic              trip_req,
    output logic              irq
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] th_a;
        logic [CNT_W-1:0] th_b;
        logic [CNT_W-1:0] th_c;
        logic [CNT_W-1:0] count;
        logic [LVL_W-1:0] lvl;
        logic             ovf;
        logic             valid;
        logic             irq;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic             ctrl_wr, stat_clr, run;
    logic             win_done;
    logic [CNT_W-1:0] win_result;
    logic [LVL_W-1:0] lvl_new;
    logic             ovf_new;
    logic [3:0]       lvl_irq_en;
    logic             raise;
    logic [2:0]       state_code;
    logic             cur_valid, cur_stop;
    logic [CNT_W-1:0] cur_count;

    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign stat_clr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT)) && reg_wdata[8];
    assign run      = !r_q.ctrl.stop && (|r_q.ctrl.ivl_len) && (|r_q.ctrl.win_len);

    tmon_window #(
        .CNT_W(CNT_W), .EDGE_W(EDGE_W), .IVL_W(IVL_W),
        .WIN_W(WIN_W), .WIN_SHIFT(WIN_SHIFT)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ctrl_wr),
        .ivl_len (r_q.ctrl.ivl_len),
        .win_len (r_q.ctrl.win_len),
        .edges   (osc_edges),
        .done    (win_done),
        .result  (win_result)
    );

    tmon_level #(
        .CNT_W(CNT_W), .NUM_TH(NUM_TH), .LVL_W(LVL_W)
    ) u_level (
        .thr   ({r_q.th_c, r_q.th_b, r_q.th_a}),
        .count (win_result),
        .level (lvl_new),
        .ovf   (ovf_new)
    );

    assign state_code = r_q.ovf ? STATE_OVF : {1'b0, r_q.lvl};
    assign cur_valid  = r_q.valid;
    assign cur_stop   = r_q.ctrl.stop;
    assign cur_count  = r_q.count;

    always_comb begin
        r_d        = r_q;
        lvl_irq_en = {r_q.ctrl.irq_l3_en, r_q.ctrl.irq_l2_en, r_q.ctrl.thr_en, 1'b0};
        raise      = ovf_new ? (!r_q.ovf && r_q.ctrl.irq_ovf_en)
                             : ((lvl_new > r_q.lvl) && lvl_irq_en[lvl_new]);

        if (ctrl_wr) begin
            r_d.ctrl      = ctrl_t'(reg_wdata);
            r_d.ctrl.rsvd = 1'b0;
            r_d.valid     = 1'b0;
        end
        if (reg_wr && (reg_addr == ADDR_W'(OFF_THAB))) begin
            r_d.th_a = reg_wdata[15:0];
            r_d.th_b = reg_wdata[31:16];
        end
        if (reg_wr && (reg_addr == ADDR_W'(OFF_THC))) begin
            r_d.th_c = reg_wdata[15:0];
        end
        if (stat_clr) r_d.irq = 1'b0;
        if (!run)     r_d.valid = 1'b0;

        if (win_done) begin
            r_d.count = win_result;
            r_d.valid = 1'b1;
            r_d.ovf   = ovf_new;
            r_d.lvl   = ovf_new ? LVL_W'(3) : lvl_new;
            if (raise) r_d.irq = 1'b1;
        end

        case (reg_addr)
            ADDR_W'(OFF_CTRL): r_d.rdata = 32'(r_q.ctrl);
            ADDR_W'(OFF_THAB): r_d.rdata = {r_q.th_b, r_q.th_a};
            ADDR_W'(OFF_THC):  r_d.rdata = {16'h0, r_q.th_c};
            ADDR_W'(OFF_STAT): r_d.rdata = {22'h0, r_q.valid, r_q.irq, 5'h0, state_code};
            ADDR_W'(OFF_CNT):  r_d.rdata = {r_q.count, 16'h0};
            default:           r_d.rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata    = r_q.rdata;
    assign irq          = r_q.irq;
    assign throttle_req = r_q.valid && r_q.ctrl.thr_en   && (r_q.lvl >= LVL_W'(1));
    assign halve_req    = r_q.valid && r_q.ctrl.halve_en && (r_q.lvl >= LVL_W'(2));
    assign trip_req     = r_q.valid && r_q.ctrl.trip_en  && (r_q.lvl == LVL_W'(3));

endmodule

// File: rtl/tmon_checker.sv
module tmon_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        stat_clr,
    input logic        cur_stop,
    input logic        cur_valid,
    input logic        irq,
    input logic        win_done,
    input logic [15:0] win_result,
    input logic [15:0] cur_count,
    input logic [2:0]  state_code,
    input logic        trip_req
);

    // R6: a control write drops the valid flag on the next cycle
    a_r6_ctrl_write_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !cur_valid);

    // R6: a stopped channel never finishes a window
    a_r6_stop_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        cur_stop |-> !win_done);

    // R3: the published count moves only after a window end
    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> $stable(cur_count));

    // R5: a saturated window result shows as the overflow state
    a_r5_overflow_state: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (win_result == 16'hFFFF)) |=> (state_code == 3'd5));

    // R9: the interrupt stays set until software clears it
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> irq);

    // R8: the interrupt rises only at a window end
    a_r8_irq_only_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !win_done) |=> !irq);

    // R7: the trip request needs a valid level-3 or overflow state
    a_r7_trip_needs_level3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |-> (cur_valid && ((state_code == 3'd3) || (state_code == 3'd5))));

endmodule

bind thermal_count_monitor tmon_checker u_chk (.*);

// File: tb/thermal_count_monitor_tb.sv
`timescale 1ns/1ps
module thermal_count_monitor_tb;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_THAB = 8'h08;
    localparam logic [7:0] A_THC  = 8'h0C;
    localparam logic [7:0] A_STAT = 8'h18;
    localparam logic [7:0] A_CNT  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  osc_edges = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        throttle_req, halve_req, trip_req, irq;

    int n_chk = 0;
    int n_err = 0;
    int unsigned cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    thermal_count_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .osc_edges(osc_edges),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .throttle_req(throttle_req),
        .halve_req(halve_req), .trip_req(trip_req), .irq(irq)
    );

    function automatic logic [31:0] ctrl_word(input logic [7:0] n, input logic [15:0] m,
                                              input logic [7:0] flags);
        return {n, m, flags};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_valid(input string tag);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, v);
            if (v[9]) break;
        end
        check({tag, " valid reached"}, {31'h0, v[9]}, 32'h1);
    endtask

    task automatic wait_count(input logic [15:0] val, input logic equal, output int unsigned t);
        t = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((reg_rdata[31:16] == val) == equal) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 outputs after reset", {28'h0, throttle_req, halve_req, trip_req, irq}, 32'h0);
        osc_edges = 5'd5;
        repeat (200) @(negedge clk);
        rd(A_CTRL, v); check("R1 control reads zero", v, 32'h0);
        rd(A_STAT, v); check("R1 status zero, no valid", v, 32'h0);
        rd(A_CNT, v);  check("R1 count zero", v, 32'h0);
    endtask

    task automatic t_period;
        int unsigned t0, t1;
        osc_edges = 5'd2;
        wr(A_CTRL, ctrl_word(8'd1, 16'd100, 8'h00));
        reg_addr = A_CNT;
        wait_count(16'd32, 1'b1, t0);
        check("R2 first window count 16*2", {16'h0, reg_rdata[31:16]}, 32'd32);
        osc_edges = 5'd3;
        wait_count(16'd32, 1'b0, t1);
        check("R3 period set by interval M", t1 - t0, 32'd100);
        check("R2 second window count 16*3", {16'h0, reg_rdata[31:16]}, 32'd48);

        osc_edges = 5'd4;
        wr(A_CTRL, ctrl_word(8'd1, 16'd5, 8'h00));
        reg_addr = A_CNT;
        wait_count(16'd64, 1'b1, t0);
        osc_edges = 5'd5;
        wait_count(16'd64, 1'b0, t1);
        check("R3 period set by window length", t1 - t0, 32'd16);
        check("R2 back-to-back window mixed sum", {16'h0, reg_rdata[31:16]}, 32'd79);
    endtask

    task automatic lvl_step(input string tag, input logic [4:0] e, input logic [7:0] flags,
                            input logic [2:0] st, input logic exp_irq,
                            input logic [2:0] acts);
        logic [31:0] v;
        osc_edges = e;
        wr(A_CTRL, ctrl_word(8'd1, 16'd40, flags));
        wait_valid(tag);
        rd(A_STAT, v);
        check({tag, " state field"}, {29'h0, v[2:0]}, {29'h0, st});
        check({tag, " irq flag"}, {30'h0, v[8], irq}, {30'h0, exp_irq, exp_irq});
        check({tag, " throttle/halve/trip"}, {29'h0, throttle_req, halve_req, trip_req},
              {29'h0, acts});
    endtask

    task automatic t_levels;
        logic [31:0] v;
        wr(A_THAB, {16'd64, 16'd32});
        wr(A_THC, 32'hABCD_0060);
        rd(A_THAB, v); check("R10 threshold A/B readback", v, {16'd64, 16'd32});
        rd(A_THC, v);  check("R10 threshold C upper bits read zero", v, 32'h0000_0060);
        lvl_step("R8 fall to level 0 no irq", 5'd1, 8'h7E, 3'd0, 1'b0, 3'b000);
        lvl_step("R4 R7 R8 count==A, throttle+irq disabled", 5'd2, 8'h76, 3'd1, 1'b0, 3'b000);
        lvl_step("R4 back to level 0", 5'd1, 8'h7E, 3'd0, 1'b0, 3'b000);
        lvl_step("R8 rise to level 1", 5'd2, 8'h7E, 3'd1, 1'b1, 3'b100);
        wr(A_STAT, 32'h0000_0001);
        rd(A_STAT, v); check("R9 write bit8=0 keeps irq", {31'h0, v[8]}, 32'h1);
        wr(A_STAT, 32'h0000_0100);
        rd(A_STAT, v); check("R9 write bit8=1 clears irq", {30'h0, v[8], irq}, 32'h0);
        lvl_step("R4 R7 count==B level 2", 5'd4, 8'h7E, 3'd2, 1'b1, 3'b110);
        wr(A_STAT, 32'h0000_0100);
        lvl_step("R4 R7 count==C level 3", 5'd6, 8'h7E, 3'd3, 1'b1, 3'b111);
        wr(A_STAT, 32'h0000_0100);
        lvl_step("R8 fall to level 1 no irq", 5'd3, 8'h7E, 3'd1, 1'b0, 3'b100);
        wr(A_CTRL, ctrl_word(8'd1, 16'd40, 8'h7E));
        check("R7 actions drop when valid clears", {31'h0, throttle_req}, 32'h0);
        rd(A_STAT, v); check("R6 control write clears valid", {31'h0, v[9]}, 32'h0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        osc_edges = 5'd31;
        wr(A_CTRL, ctrl_word(8'd200, 16'd10, 8'h14));
        wait_valid("R5 overflow window");
        rd(A_CNT, v);  check("R5 count saturates", v, 32'hFFFF_0000);
        rd(A_STAT, v); check("R5 R8 state 5 with irq", v & 32'h0000_0107, 32'h0000_0105);
        check("R5 R7 trip asserted on overflow", {31'h0, trip_req}, 32'h1);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        osc_edges = 5'd2;
        wr(A_CTRL, ctrl_word(8'd1, 16'd40, 8'hFF));
        rd(A_CTRL, v); check("R10 control readback, bit7 zero", v, 32'h0100_287F);
        repeat (300) @(negedge clk);
        rd(A_STAT, v); check("R6 stop keeps valid clear", {31'h0, v[9]}, 32'h0);
        rd(A_CNT, v);  check("R6 stop keeps old count", v, 32'hFFFF_0000);
        check("R7 no trip while stopped", {31'h0, trip_req}, 32'h0);
        wr(A_CTRL, ctrl_word(8'd1, 16'd40, 8'h00));
        wait_valid("R6 resume after stop");
        rd(A_CNT, v);  check("R6 resume measures again", v, {16'd32, 16'h0});
    endtask

    initial begin
        #3800000;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_levels();
        t_overflow();
        t_stop();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule